// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block is the digital sequencer in front of a successive-approximation converter core. A conversion can start in two ways. Software can pulse a start request. A hardware event can also start one when hardware triggering is on. The event is an edge or a period point on one of three PWM channels, or an edge on an external start pin. The controller raises a busy indication. For hardware events it counts down a programmable delay. It then sends a single-cycle start pulse to the core and waits for the core's done strobe.

On completion the 12-bit sample is split into a high byte and a low nibble, both captured in the same cycle. A sticky completion flag is set, and an interrupt request follows the flag when the interrupt is enabled. Every start request is dropped without notice while a conversion is pending. A module enable gates the whole controller. Dropping the enable returns it to idle.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While `en` is 0, no start request is accepted and `core_done` has no effect. When `en` goes low during a conversion, `busy` reads 0 from the next cycle onward.
- R2: A `sw_start` pulse taken while idle makes `busy` read 1 on the following cycle. `busy` stays 1 until the clock edge that samples `core_done` during conversion, and reads 0 from then on.
- R3: `core_start` is high for exactly one cycle per conversion, and only while `busy` is 1.
- R4: At completion, `res_hi` takes bits 11:4 of `core_data` and `res_lo` takes bits 3:0. Both update on the same edge that sets `flag`, and they change at no other time.
- R5: `flag` stays 1 until a `flag_clr` pulse. When completion and `flag_clr` fall in the same cycle, the flag ends up set.
- R6: `irq` is 1 exactly when `flag` and `ie` are both 1.
- R7: With `hw_trig_en` set, `trig_src` picks the event source: 0, 1 and 2 select PWM channels 0 to 2, and 3 selects the external pin. With `hw_trig_en` clear, every hardware event is ignored.
- R8: `trig_type` picks the qualifying event. 00 is a falling edge of the selected level. 01 is a rising edge. 10 is the channel's centre-point pulse. 11 is the channel's end-point pulse. With source 3, types 10 and 11 never trigger.
- R9: A hardware event with `trig_dly` = D makes `busy` read 1 on the next cycle, and `core_start` is high D cycles after that first busy cycle. With D = 0 the two coincide. A software start always behaves as D = 0.
- R10: The external pin passes through a two-stage synchroniser. A qualifying pin edge driven between clock edges gives `busy` = 1 after the third rising clock edge that follows.
- R11: A software or hardware request that arrives while `busy` is 1 is discarded. It produces no further `core_start`, no second conversion and no indication of any kind.
- R12: When a software request and a hardware event arrive in the same idle cycle, the software request wins and starts with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| hw_trig_en | input | 1 | Hardware trigger enable |
| trig_src | input | 2 | Trigger source select |
| trig_type | input | 2 | Qualifying event type |
| trig_dly | input | DLY_W | Hardware trigger delay in clocks |
| ie | input | 1 | Interrupt enable |
| sw_start | input | 1 | Software start request pulse |
| flag_clr | input | 1 | Completion flag clear pulse |
| pwm_lvl | input | 3 | PWM channel output levels |
| pwm_ctr | input | 3 | PWM centre-point pulses, one per channel |
| pwm_end | input | 3 | PWM end-point pulses, one per channel |
| ext_start_pin | input | 1 | Asynchronous external start pin |
| core_done | input | 1 | Converter core done strobe |
| core_data | input | RES_W | Converter core sample |
| core_start | output | 1 | Start pulse to converter core |
| busy | output | 1 | Conversion pending or in progress |
| flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| res_hi | output | 8 | Result bits 11:4 |
| res_lo | output | RES_W-8 | Result bits 3:0 |

## Verification
The bench sends a second software start and a PWM edge while a conversion is underway. A design that retriggered would issue a second `core_start` or hold `busy` after the done strobe. The delay path is timed cycle by cycle, and so is the three-edge pin synchroniser. An off-by-one counter or a missing synchroniser stage shows up as a `core_start` or `busy` one cycle early or late. The mismatched period-point cases also matter. A centre pulse while end-point is selected, and a period-point type on the pin, must start nothing; a decoder that mixed up the type field would convert there. Dropping `en` mid-conversion and then strobing `core_done` catches a design that still latches the result or sets the flag. A clear that coincides with completion catches the wrong priority on the flag.

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
  parameter int RES_W = 12,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hw_trig_en,
  input  logic [1:0]       trig_src,
  input  logic [1:0]       trig_type,
  input  logic [DLY_W-1:0] trig_dly,
  input  logic             ie,
  input  logic             sw_start,
  input  logic             flag_clr,
  input  logic [2:0]       pwm_lvl,
  input  logic [2:0]       pwm_ctr,
  input  logic [2:0]       pwm_end,
  input  logic             ext_start_pin,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_data,
  output logic             core_start,
  output logic             busy,
  output logic             flag,
  output logic             irq,
  output logic [7:0]       res_hi,
  output logic [RES_W-9:0] res_lo
);
  localparam int LO_W = RES_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} state_t;
  state_t state;

  logic [DLY_W-1:0] cnt;
  logic [1:0] pin_sync;
  logic [3:0] lvl, lvl_q, ctr_v, end_v;
  logic cur, prv, hw_evt, sw_req, hw_req, done_evt;

  assign lvl   = {pin_sync[1], pwm_lvl};
  assign ctr_v = {1'b0, pwm_ctr};
  assign end_v = {1'b0, pwm_end};
  assign cur   = lvl[trig_src];
  assign prv   = lvl_q[trig_src];

  always_comb begin
    case (trig_type)
      2'b00:   hw_evt = prv & ~cur;
      2'b01:   hw_evt = cur & ~prv;
      2'b10:   hw_evt = ctr_v[trig_src];
      default: hw_evt = end_v[trig_src];
    endcase
  end

  assign sw_req     = en & sw_start;
  assign hw_req     = en & hw_trig_en & hw_evt;
  assign done_evt   = en & (state == S_CONV) & core_done;
  assign busy       = (state != S_IDLE);
  assign core_start = (state == S_WAIT) && (cnt == '0);
  assign irq        = flag & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= '0;
      lvl_q    <= '0;
    end else begin
      pin_sync <= {pin_sync[0], ext_start_pin};
      lvl_q    <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (!en) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (sw_req) begin
            state <= S_WAIT;
            cnt   <= '0;
          end else if (hw_req) begin
            state <= S_WAIT;
            cnt   <= trig_dly;
          end
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_CONV;
          else           cnt   <= cnt - 1'b1;
        end
        S_CONV:  if (core_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      res_hi <= '0;
      res_lo <= '0;
    end else if (done_evt) begin
      flag   <= 1'b1;
      res_hi <= core_data[RES_W-1 -: 8];
      res_lo <= core_data[LO_W-1:0];
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             core_start,
  input logic             busy,
  input logic             flag,
  input logic [7:0]       res_hi,
  input logic [RES_W-9:0] res_lo
);
  assert_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (!busy && $past(busy)));

  assert_start_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> busy);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  assert_result_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({res_hi, res_lo}) |-> flag);

  assert_busy_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .core_start(core_start), .busy(busy),
  .flag(flag), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;
  logic clk = 0, rst_n = 0;
  logic en = 0, hw_trig_en = 0, ie = 0, sw_start = 0, flag_clr = 0;
  logic [1:0] trig_src = 0, trig_type = 0;
  logic [7:0] trig_dly = 0;
  logic [2:0] pwm_lvl = 0, pwm_ctr = 0, pwm_end = 0;
  logic ext_start_pin = 0, core_done = 0;
  logic [11:0] core_data = 0;
  logic core_start, busy, flag, irq;
  logic [7:0] res_hi;
  logic [3:0] res_lo;
  int checks = 0, failures = 0, nstart = 0;

  always #4 clk = ~clk;

  adc_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en(en), .hw_trig_en(hw_trig_en),
    .trig_src(trig_src), .trig_type(trig_type), .trig_dly(trig_dly),
    .ie(ie), .sw_start(sw_start), .flag_clr(flag_clr), .pwm_lvl(pwm_lvl),
    .pwm_ctr(pwm_ctr), .pwm_end(pwm_end), .ext_start_pin(ext_start_pin),
    .core_done(core_done), .core_data(core_data), .core_start(core_start),
    .busy(busy), .flag(flag), .irq(irq), .res_hi(res_hi), .res_lo(res_lo)
  );

  always @(negedge clk) if (core_start) nstart++;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_conv(logic [11:0] d);
    core_done = 1; core_data = d;
    tick();
    core_done = 0;
  endtask

  task automatic t_reset;
    chk("R2 reset busy", busy, 0);
    chk("R4 reset res", {res_hi, res_lo}, 0);
    chk("R5 reset flag", flag, 0);
    chk("R6 reset irq", irq, 0);
    chk("R3 reset core_start", core_start, 0);
  endtask

  task automatic t_sw_start;
    sw_start = 1; tick(); sw_start = 0;
    chk("R2 busy after sw", busy, 1);
    chk("R9 sw no delay", core_start, 1);
    tick();
    chk("R3 start one cycle", core_start, 0);
    tick(3);
    chk("R2 busy held", busy, 1);
    finish_conv(12'hABC);
    chk("R2 busy clears", busy, 0);
    chk("R4 res_hi", res_hi, 8'hAB);
    chk("R4 res_lo", res_lo, 4'hC);
    chk("R4 flag set", flag, 1);
    chk("R6 irq off when ie=0", irq, 0);
  endtask

  task automatic t_irq_flag;
    ie = 1; #1;
    chk("R6 irq follows ie", irq, 1);
    tick(3);
    chk("R5 flag sticky", flag, 1);
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R5 flag cleared", flag, 0);
    chk("R6 irq drops", irq, 0);
    sw_start = 1; tick(); sw_start = 0;
    tick(2);
    flag_clr = 1;
    finish_conv(12'h123);
    flag_clr = 0;
    chk("R5 set wins over clear", flag, 1);
    chk("R4 res second", {res_hi, res_lo}, 12'h123);
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic t_busy_drop;
    int s0;
    s0 = nstart;
    sw_start = 1; tick(); sw_start = 0;
    tick(2);
    sw_start = 1; hw_trig_en = 1; trig_src = 1; trig_type = 1; pwm_lvl = 3'b010;
    tick(); sw_start = 0;
    tick(2);
    finish_conv(12'h456);
    chk("R11 busy clears once", busy, 0);
    tick(4);
    chk("R11 no retrigger", busy, 0);
    chk("R11 single core_start", nstart - s0, 1);
    chk("R11 result", {res_hi, res_lo}, 12'h456);
    hw_trig_en = 0; pwm_lvl = 0; tick(2);
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic t_disable;
    int s0;
    s0 = nstart;
    en = 0;
    sw_start = 1; tick(); sw_start = 0;
    chk("R1 sw ignored", busy, 0);
    chk("R1 no start", nstart - s0, 0);
    en = 1;
    sw_start = 1; tick(); sw_start = 0;
    tick(2);
    en = 0; tick();
    chk("R1 busy drops", busy, 0);
    finish_conv(12'hFFF);
    chk("R1 done ignored flag", flag, 0);
    chk("R1 done ignored res", {res_hi, res_lo}, 12'h456);
    en = 1; tick();
  endtask

  task automatic t_hw_delay;
    trig_dly = 3; trig_src = 1; trig_type = 1; hw_trig_en = 1;
    tick();
    pwm_lvl = 3'b010; tick();
    chk("R9 busy after event", busy, 1);
    chk("R9 no start yet", core_start, 0);
    tick(2);
    chk("R9 still waiting", core_start, 0);
    tick();
    chk("R9 start after D", core_start, 1);
    tick();
    finish_conv(12'h789);
    chk("R7 hw conversion", {res_hi, res_lo}, 12'h789);
    pwm_lvl = 0; hw_trig_en = 0; trig_dly = 0; tick();
  endtask

  task automatic t_hw_fall;
    pwm_lvl = 3'b001; tick(2);
    trig_src = 0; trig_type = 0; hw_trig_en = 1; tick();
    chk("R8 no event on steady high", busy, 0);
    pwm_lvl = 3'b000; tick();
    chk("R8 falling edge", busy, 1);
    chk("R9 zero delay", core_start, 1);
    tick();
    finish_conv(12'h111);
    hw_trig_en = 0; tick();
  endtask

  task automatic t_points;
    hw_trig_en = 1; trig_src = 2; trig_type = 3;
    pwm_ctr = 3'b100; tick(); pwm_ctr = 0;
    chk("R8 centre ignored in end mode", busy, 0);
    pwm_end = 3'b010; tick(); pwm_end = 0;
    chk("R8 other channel ignored", busy, 0);
    pwm_end = 3'b100; tick(); pwm_end = 0;
    chk("R8 end point", busy, 1);
    tick();
    finish_conv(12'h222);
    trig_type = 2;
    pwm_ctr = 3'b100; tick(); pwm_ctr = 0;
    chk("R8 centre point", busy, 1);
    tick();
    finish_conv(12'h333);
    hw_trig_en = 0;
    pwm_ctr = 3'b100; tick(); pwm_ctr = 0;
    chk("R7 hw disabled", busy, 0);
  endtask

  task automatic t_pin;
    hw_trig_en = 1; trig_src = 3; trig_type = 1;
    ext_start_pin = 1;
    tick(2);
    chk("R10 not yet after two edges", busy, 0);
    tick();
    chk("R10 busy after three edges", busy, 1);
    tick();
    finish_conv(12'h444);
    trig_type = 2; pwm_ctr = 3'b111; ext_start_pin = 0;
    tick(4); pwm_ctr = 0;
    chk("R8 pin with point type", busy, 0);
    trig_type = 3; ext_start_pin = 1; tick(4);
    chk("R8 pin end type", busy, 0);
    hw_trig_en = 0; ext_start_pin = 0; tick(3);
  endtask

  task automatic t_prio;
    trig_src = 1; trig_type = 1; trig_dly = 5; hw_trig_en = 1;
    sw_start = 1; pwm_lvl = 3'b010; tick(); sw_start = 0;
    chk("R12 sw wins no delay", core_start, 1);
    tick();
    finish_conv(12'h555);
    hw_trig_en = 0; pwm_lvl = 0; trig_dly = 0; tick();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    t_reset();
    en = 1; tick();
    t_sw_start();
    t_irq_flag();
    t_busy_drop();
    t_disable();
    t_hw_delay();
    t_hw_fall();
    t_points();
    t_pin();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule